// File: doc/BRIEF.md
# Presettable Cascadable BCD Decade Counter

A four-bit synchronous up-counter that steps through the decimal digits 0 to 9 in 8421 binary-coded decimal and rolls from 9 back to 0. It can be preset from a four-bit data word, which makes it useful as a programmable divider. It is built to be chained into multi-digit counters that stay fully synchronous: every stage shares one clock, and a combinational terminal-count flag carries forward into the next stage.

Two active-high enables gate counting. One of them, `carry_in`, also qualifies the terminal-count flag, so a chain of stages forms a carry-lookahead path with no extra logic. The other, `cnt_en`, is fanned out to every stage. An active-low reset, an active-low load and the count enables follow a fixed precedence. A parameter sets the reset to either asynchronous (clears at once) or synchronous (clears on the next rising edge).

A load can place a value from 10 to 15 in the counter. Each such value has a defined successor (0), so a single count step brings the counter back into the decimal sequence.

Top module: `bcd_decade_counter`

## Requirements
- R1: With ASYNC_RESET=1, driving `rst_n` low sets `q` to 0 at once, with no clock edge needed, whatever the other inputs are, and `q` stays 0 while `rst_n` is low.
- R2: With ASYNC_RESET=0, `q` is 0 after any rising edge at which `rst_n` is low, even if `load_n` is low or counting is enabled; before that edge `q` keeps its value.
- R3: With reset inactive and `load_n` low, `q` takes the value of `din` at the rising edge, whatever the levels of `cnt_en` and `carry_in`.
- R4: With `rst_n` and `load_n` high and both `cnt_en` and `carry_in` high, `q` rises by one at each rising edge while it is below 9.
- R5: With `rst_n` and `load_n` high and either `cnt_en` or `carry_in` low, `q` keeps its value across the rising edge.
- R6: A count step from 9 gives 0.
- R7: `tc` is high exactly when `q` equals 9 and `carry_in` is high. It follows `carry_in` with no clock, and `cnt_en` has no effect on it.
- R8: Once loaded, a value from 10 to 15 is held when counting is disabled, gives 0 on the next count step, and never raises `tc`.
- R9: Pulses on `load_n`, `din` and `cnt_en` between rising edges, settled again before the next edge, leave `q` unchanged.
- R10: Two stages with a shared `cnt_en`, the low stage's `tc` driving the high stage's `carry_in`, count 00 to 99 in step and wrap to 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge, except the asynchronous clear |
| rst_n | input | 1 | Active-low reset; asynchronous or synchronous depending on ASYNC_RESET |
| load_n | input | 1 | Active-low preset; loads `din` at the rising edge |
| din | input | 4 | Preset value |
| cnt_en | input | 1 | Count enable shared by every stage of a chain |
| carry_in | input | 1 | Count enable that also qualifies `tc`; driven by the previous stage's `tc` |
| q | output | 4 | Current count, 8421 BCD |
| tc | output | 1 | Terminal count: `q` is 9 and `carry_in` is high |

## Verification
`q` changes one rising edge after a load, count, hold or synchronous reset is applied. `tc` responds in the same cycle to `q` and `carry_in`, and the asynchronous clear reaches `q` with no edge at all. The bench drives inputs on the falling edge and samples 2 ns later. So each sample shows the state after the previous rising edge, combined with the freshly driven `carry_in` and `rst_n`. That makes `tc` and the asynchronous clear visible in the cycle they are due. The reference model advances only at the rising edge, so a loaded or counted value is expected exactly one edge later. The synchronous-reset stage is expected to keep its old value until that edge.

// File: rtl/bcd_ctr_pkg.sv
package bcd_ctr_pkg;
   localparam int DIGIT_W = 4;
   localparam logic [DIGIT_W-1:0] TOP_DIGIT = DIGIT_W'(9);

   typedef logic [DIGIT_W-1:0] digit_t;

   // Priority order: CLEAR > LOAD > COUNT > HOLD
   typedef enum logic [1:0] {
      MODE_HOLD  = 2'd0,
      MODE_COUNT = 2'd1,
      MODE_LOAD  = 2'd2,
      MODE_CLEAR = 2'd3
   } mode_e;
endpackage

// File: rtl/bcd_mode_sel.sv
module bcd_mode_sel
   import bcd_ctr_pkg::*;
(
   input  logic  clr_req,
   input  logic  load_n,
   input  logic  cnt_en,
   input  logic  carry_in,
   output mode_e mode
);
   always_comb begin
      if (clr_req)                  mode = MODE_CLEAR;
      else if (!load_n)             mode = MODE_LOAD;
      else if (cnt_en && carry_in)  mode = MODE_COUNT;
      else                          mode = MODE_HOLD;
   end
endmodule

// File: rtl/bcd_incr.sv
module bcd_incr
   import bcd_ctr_pkg::*;
(
   input  digit_t cur,
   output digit_t nxt
);
   // 9 and every non-decimal code step to zero
   assign nxt = (cur >= TOP_DIGIT) ? '0 : cur + digit_t'(1);
endmodule

// File: rtl/bcd_term_detect.sv
module bcd_term_detect
   import bcd_ctr_pkg::*;
(
   input  digit_t cur,
   input  logic   carry_in,
   output logic   tc
);
   assign tc = carry_in && (cur == TOP_DIGIT);
endmodule

// File: rtl/bcd_decade_counter.sv
module bcd_decade_counter
   import bcd_ctr_pkg::*;
#(
   parameter int ASYNC_RESET = 1
)
(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load_n,
   input  logic [DIGIT_W-1:0] din,
   input  logic               cnt_en,
   input  logic               carry_in,
   output logic [DIGIT_W-1:0] q,
   output logic               tc
);
   localparam bit USE_ASYNC = (ASYNC_RESET != 0);

   if (ASYNC_RESET != 0 && ASYNC_RESET != 1) begin : g_bad_param
      $error("bcd_decade_counter: ASYNC_RESET must be 0 or 1");
   end

   mode_e  mode;
   digit_t cnt_q;
   digit_t cnt_inc;
   digit_t cnt_d;
   logic   clr_req;

   // Asynchronous variant clears in the register; synchronous one via mode
   assign clr_req = USE_ASYNC ? 1'b0 : ~rst_n;

   bcd_mode_sel u_mode (
      .clr_req  (clr_req),
      .load_n   (load_n),
      .cnt_en   (cnt_en),
      .carry_in (carry_in),
      .mode     (mode)
   );

   bcd_incr u_inc (
      .cur (cnt_q),
      .nxt (cnt_inc)
   );

   always_comb begin
      unique case (mode)
         MODE_CLEAR: cnt_d = '0;
         MODE_LOAD:  cnt_d = din;
         MODE_COUNT: cnt_d = cnt_inc;
         default:    cnt_d = cnt_q;
      endcase
   end

   if (USE_ASYNC) begin : g_async
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) cnt_q <= '0;
         else        cnt_q <= cnt_d;
      end
   end else begin : g_sync
      always_ff @(posedge clk) begin
         cnt_q <= cnt_d;
      end
   end

   bcd_term_detect u_tc (
      .cur      (cnt_q),
      .carry_in (carry_in),
      .tc       (tc)
   );

   assign q = cnt_q;
endmodule

// File: rtl/bcd_counter_chk.sv
module bcd_counter_chk #(
   parameter int ASYNC_RESET = 1
)
(
   input logic       clk,
   input logic       rst_n,
   input logic       load_n,
   input logic [3:0] din,
   input logic       cnt_en,
   input logic       carry_in,
   input logic [3:0] q,
   input logic       tc
);
   logic past_valid = 1'b0;
   always_ff @(posedge clk) past_valid <= 1'b1;

   AST_ASYNC_CLEAR: assert property (@(posedge clk)
      (ASYNC_RESET == 1 && !rst_n) |-> (q == 4'd0)); // R1

   AST_CLEAR_AFTER_EDGE: assert property (@(posedge clk)
      (past_valid && !$past(rst_n)) |-> (q == 4'd0)); // R2

   AST_LOAD_TAKES_DIN: assert property (@(posedge clk) disable iff (!rst_n)
      !load_n |=> (q == $past(din))); // R3

   AST_COUNT_UP: assert property (@(posedge clk) disable iff (!rst_n)
      (load_n && cnt_en && carry_in && q < 4'd9) |=> (q == $past(q) + 4'd1)); // R4

   AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (load_n && !(cnt_en && carry_in)) |=> $stable(q)); // R5

   AST_WRAP_NINE: assert property (@(posedge clk) disable iff (!rst_n)
      (load_n && cnt_en && carry_in && q == 4'd9) |=> (q == 4'd0)); // R6

   AST_TC_DECIMAL_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      tc |-> (q == 4'd9)); // R7

   AST_ILLEGAL_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
      (load_n && cnt_en && carry_in && q > 4'd9) |=> (q == 4'd0)); // R8
endmodule

bind bcd_decade_counter bcd_counter_chk #(.ASYNC_RESET(ASYNC_RESET)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .load_n   (load_n),
   .din      (din),
   .cnt_en   (cnt_en),
   .carry_in (carry_in),
   .q        (q),
   .tc       (tc)
);

// File: tb/sim_bcd_decade_counter.sv
`timescale 1ns/1ps
module sim_bcd_decade_counter;
   localparam int CLK_HALF = 10;
   localparam int MAX_CYCLES = 200000;

   logic       clk = 1'b0;
   logic       rst_n = 1'b1;
   logic       load_n = 1'b1;
   logic [3:0] din_lo = 4'd0;
   logic [3:0] din_hi = 4'd0;
   logic       cnt_en = 1'b0;
   logic       carry_in = 1'b0;
   logic [3:0] q0, q1, q2;
   logic       tc0, tc1, tc2;

   int nvec = 0;
   int nfail = 0;
   int m_lo = 0, m_hi = 0, m_s = 0;
   bit s_valid = 1'b0;

   always #CLK_HALF clk = ~clk;

   // low digit (asynchronous reset)
   bcd_decade_counter #(.ASYNC_RESET(1)) u0 (
      .clk(clk), .rst_n(rst_n), .load_n(load_n), .din(din_lo),
      .cnt_en(cnt_en), .carry_in(carry_in), .q(q0), .tc(tc0));
   // high digit, chained on the low digit's terminal count
   bcd_decade_counter #(.ASYNC_RESET(1)) u1 (
      .clk(clk), .rst_n(rst_n), .load_n(load_n), .din(din_hi),
      .cnt_en(cnt_en), .carry_in(tc0), .q(q1), .tc(tc1));
   // synchronous-reset variant, same controls as the low digit
   bcd_decade_counter #(.ASYNC_RESET(0)) u2 (
      .clk(clk), .rst_n(rst_n), .load_n(load_n), .din(din_lo),
      .cnt_en(cnt_en), .carry_in(carry_in), .q(q2), .tc(tc2));

   function automatic int nxt(int cur, bit clr, bit ld_n, int d, bit ce, bit ci);
      if (clr) return 0;
      if (!ld_n) return d;
      if (ce && ci) return (cur >= 9) ? 0 : cur + 1;
      return cur;
   endfunction

   task automatic chk(input string tag, input int got, input int exp);
      nvec++;
      if (got != exp) begin
         nfail++;
         $display("FAIL %s: got %0d expected %0d", tag, got, exp);
      end
   endtask

   task automatic compare(input string tag);
      bit lo_carry;
      lo_carry = (m_lo == 9) && carry_in;
      chk({tag, " low digit"}, int'(q0), m_lo);
      chk({tag, " high digit"}, int'(q1), m_hi);
      chk("R7 tc low", int'(tc0), int'(lo_carry));
      chk("R7 tc high", int'(tc1), int'((m_hi == 9) && lo_carry));
      if (s_valid) begin
         chk({tag, " sync variant"}, int'(q2), m_s);
         chk("R7 tc sync", int'(tc2), int'((m_s == 9) && carry_in));
      end
   endtask

   task automatic advance();
      int nlo, nhi, ns;
      bit hi_ci;
      hi_ci = (m_lo == 9) && carry_in;
      nlo = nxt(m_lo, !rst_n, load_n, int'(din_lo), cnt_en, carry_in);
      nhi = nxt(m_hi, !rst_n, load_n, int'(din_hi), cnt_en, hi_ci);
      ns  = nxt(m_s,  !rst_n, load_n, int'(din_lo), cnt_en, carry_in);
      if (!rst_n || !load_n) s_valid = 1'b1;
      m_lo = nlo; m_hi = nhi; m_s = ns;
   endtask

   // called at a falling edge; returns at the next falling edge
   task automatic step(input string tag, input bit r, input bit l,
                       input int dl, input int dh, input bit ce, input bit ci);
      rst_n = r; load_n = l; din_lo = 4'(dl); din_hi = 4'(dh);
      cnt_en = ce; carry_in = ci;
      if (!r) begin m_lo = 0; m_hi = 0; end
      #2;
      compare(tag);
      @(posedge clk);
      advance();
      @(negedge clk);
   endtask

   task automatic glitch_step(input string tag);
      rst_n = 1'b1; load_n = 1'b1; cnt_en = 1'b0; carry_in = 1'b1;
      din_lo = 4'd5; din_hi = 4'd5;
      #2;
      compare(tag);
      load_n = 1'b0; cnt_en = 1'b1; din_lo = 4'd2;
      #3;
      load_n = 1'b1; cnt_en = 1'b0; din_lo = 4'd6;
      #2;
      compare(tag);
      @(posedge clk);
      advance();
      @(negedge clk);
   endtask

   initial begin
      #1 rst_n = 1'b0;
      @(negedge clk);
      // R1: reset overrides load and count
      step("R1", 0, 0, 5, 5, 1, 1);
      step("R1", 0, 1, 0, 0, 1, 1);
      // R3: load regardless of enables
      step("R3", 1, 0, 7, 3, 0, 0);
      step("R3", 1, 0, 7, 3, 1, 0);
      // R4: count with carry into the high digit
      for (int i = 0; i < 3; i++) step("R4", 1, 1, 0, 0, 1, 1);
      // R5: either enable low holds
      step("R5", 1, 1, 0, 0, 0, 1);
      step("R5", 1, 1, 0, 0, 0, 1);
      step("R5", 1, 1, 0, 0, 1, 0);
      step("R5", 1, 1, 0, 0, 1, 0);
      // R6: wrap from nine
      step("R6", 1, 0, 9, 9, 0, 0);
      step("R6", 1, 1, 0, 0, 1, 1);
      step("R6", 1, 1, 0, 0, 0, 0);
      // R8: non-decimal codes
      for (int v = 10; v < 16; v++) begin
         step("R8", 1, 0, v, v, 0, 0);
         step("R8", 1, 1, 0, 0, 0, 1);
         step("R8", 1, 1, 0, 0, 1, 1);
         step("R8", 1, 1, 0, 0, 0, 0);
      end
      // R9: pulses between edges have no effect
      step("R9", 1, 0, 4, 6, 0, 0);
      glitch_step("R9");
      glitch_step("R9");
      // R1 then R2: reset mid-cycle; sync variant waits for the edge
      step("R2", 1, 0, 8, 2, 0, 0);
      step("R1", 0, 0, 3, 3, 1, 1);
      step("R2", 0, 0, 3, 3, 1, 1);
      step("R2", 1, 1, 0, 0, 0, 0);
      // R10: two-digit cascade 00..99 and wrap
      step("R10", 1, 0, 0, 0, 0, 0);
      for (int i = 0; i < 100; i++) step("R10", 1, 1, 0, 0, 1, 1);
      #2;
      chk("R10 wrap low digit", int'(q0), 0);
      chk("R10 wrap high digit", int'(q1), 0);
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
   end

   initial begin
      #(longint'(MAX_CYCLES) * 2 * CLK_HALF);
      nfail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
   end
endmodule